// File: doc/BRIEF.md
# Load Result Alignment and Merge Unit

This block turns the aligned memory word returned for a load into the value that is written back to the destination register of a 32-bit core. It takes the load opcode, the two low bits of the effective address, the word read from the address with those bits cleared, and the current contents of the destination register. It then selects and extends a byte or halfword, passes a whole word through, or merges shifted memory bytes with the preserved part of the old register for the two partial-word loads that together assemble an unaligned word.

Byte lanes are numbered little-endian: lane `a` occupies bits `8a+7:8a`. The result is registered. One cycle after a load is presented with `in_valid` high, `out_valid` rises with the shaped value. A word load whose address is not word-aligned raises a misalignment flag; the aligned word is still passed through unchanged. Address generation, the memory access itself and exception handling are done elsewhere.

Top module: `ld_align_unit`

## Requirements
- R1: While `rst` is high, and at the first clock edge after it, `out_valid`, `out_data` and `out_misalign` are all zero.
- R2: `out_valid` equals `in_valid` delayed by one clock. `out_data` and `out_misalign` change only in the cycle after `in_valid` was high, and otherwise hold their values.
- R3: Opcode 32 (signed byte) returns byte lane `in_addr`, sign-extended from bit 7 of that lane.
- R4: Opcode 36 (unsigned byte) returns byte lane `in_addr`, zero-extended.
- R5: Opcode 33 (signed half) and opcode 37 (unsigned half) return bits 31:16 when `in_addr[1]` is 1 and bits 15:0 when it is 0. Opcode 33 sign-extends the halfword and opcode 37 zero-extends it. `in_addr[0]` has no effect.
- R6: Opcode 35 (word) and opcode 48 (linked word) both return `in_word` unchanged for every `in_addr`.
- R7: Opcode 34 (left merge) with `a = in_addr` returns `in_word << 8a`, with the low `a` bytes taken from `in_old`. With `a = 0` the result is the full word.
- R8: Opcode 38 (right merge) with `a = 1, 2, 3` returns `in_word >> 8(4-a)`, with the upper `4-a` bytes taken from `in_old` in place.
- R9: Opcode 38 with `in_addr = 0` returns `in_old` unchanged.
- R10: `out_misalign` is 1 only for opcodes 35 and 48 with `in_addr` not zero. It is 0 for every other opcode and address.
- R11: Any opcode other than the eight above returns `in_old` unchanged, with `out_misalign` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A load result is presented this cycle |
| in_op | input | 6 | Load opcode |
| in_addr | input | 2 | Low bits of the effective address |
| in_word | input | 32 | Aligned memory word |
| in_old | input | 32 | Current destination register value |
| out_valid | output | 1 | Registered result is valid |
| out_data | output | 32 | Value to write back |
| out_misalign | output | 1 | Word load at a non-aligned address |

## Verification
Every result is due exactly one clock edge after the cycle in which `in_valid` is high. The bench drives inputs on the falling edge, lets one rising edge capture them, and compares `out_valid`, `out_data` and `out_misalign` on the following falling edge. In the hold checks, changed inputs are presented with `in_valid` low, and the outputs are read one edge later to confirm they kept the previous values. A back-to-back pair of loads confirms that each result appears in the cycle after its own load and is not delayed further.

// File: rtl/ld_pkg.sv
package ld_pkg;

  localparam int OP_W = 6;

  localparam logic [OP_W-1:0] OPC_BYTE_S  = 6'd32;
  localparam logic [OP_W-1:0] OPC_HALF_S  = 6'd33;
  localparam logic [OP_W-1:0] OPC_LEFT    = 6'd34;
  localparam logic [OP_W-1:0] OPC_WORD    = 6'd35;
  localparam logic [OP_W-1:0] OPC_BYTE_U  = 6'd36;
  localparam logic [OP_W-1:0] OPC_HALF_U  = 6'd37;
  localparam logic [OP_W-1:0] OPC_RIGHT   = 6'd38;
  localparam logic [OP_W-1:0] OPC_LINKED  = 6'd48;

  typedef enum logic [2:0] {
    K_NONE  = 3'd0,
    K_BYTE  = 3'd1,
    K_HALF  = 3'd2,
    K_WORD  = 3'd3,
    K_LEFT  = 3'd4,
    K_RIGHT = 3'd5
  } ld_kind_e;

  typedef struct packed {
    ld_kind_e kind;
    logic     signed_ext;
  } ld_dec_t;

endpackage

// File: rtl/ld_decode.sv
module ld_decode
  import ld_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output ld_dec_t         dec
);

  always_comb begin
    dec = '{kind: K_NONE, signed_ext: 1'b0};
    case (op)
      OPC_BYTE_S: dec = '{kind: K_BYTE,  signed_ext: 1'b1};
      OPC_BYTE_U: dec = '{kind: K_BYTE,  signed_ext: 1'b0};
      OPC_HALF_S: dec = '{kind: K_HALF,  signed_ext: 1'b1};
      OPC_HALF_U: dec = '{kind: K_HALF,  signed_ext: 1'b0};
      OPC_WORD,
      OPC_LINKED: dec = '{kind: K_WORD,  signed_ext: 1'b0};
      OPC_LEFT:   dec = '{kind: K_LEFT,  signed_ext: 1'b0};
      OPC_RIGHT:  dec = '{kind: K_RIGHT, signed_ext: 1'b0};
      default:    dec = '{kind: K_NONE,  signed_ext: 1'b0};
    endcase
  end

endmodule

// File: rtl/ld_extract.sv
module ld_extract #(
  parameter int DATA_W = 32,
  localparam int NLANE = DATA_W / 8,
  localparam int AW    = $clog2(NLANE),
  localparam int NHALF = NLANE / 2
) (
  input  logic [DATA_W-1:0] word,
  input  logic [AW-1:0]     addr,
  input  logic              is_half,
  input  logic              signed_ext,
  output logic [DATA_W-1:0] ext
);

  logic [7:0]  byte_sel;
  logic [15:0] half_sel;

  // Byte lane k holds bits 8k+7:8k.
  always_comb begin
    byte_sel = '0;
    for (int k = 0; k < NLANE; k++) begin
      if (addr == AW'(k)) byte_sel = word[8*k +: 8];
    end
  end

  // Upper address bits pick the halfword; bit 0 is not looked at.
  always_comb begin
    half_sel = '0;
    for (int h = 0; h < NHALF; h++) begin
      if (addr[AW-1:1] == (AW-1)'(h)) half_sel = word[16*h +: 16];
    end
  end

  always_comb begin
    if (is_half)
      ext = {{(DATA_W-16){signed_ext & half_sel[15]}}, half_sel};
    else
      ext = {{(DATA_W-8){signed_ext & byte_sel[7]}}, byte_sel};
  end

endmodule

// File: rtl/ld_merge.sv
module ld_merge #(
  parameter int DATA_W = 32,
  localparam int NLANE = DATA_W / 8,
  localparam int AW    = $clog2(NLANE)
) (
  input  logic [DATA_W-1:0] word,
  input  logic [DATA_W-1:0] old,
  input  logic [AW-1:0]     addr,
  input  logic              left,
  output logic [DATA_W-1:0] merged
);

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    logic [7:0] l_pick;
    logic [7:0] r_pick;

    // Left merge: lane i takes word lane i-a when i >= a, else keeps old.
    always_comb begin
      l_pick = old[8*i +: 8];
      for (int k = 0; k < NLANE; k++) begin
        if (k + int'(addr) == i) l_pick = word[8*k +: 8];
      end
    end

    // Right merge: lane i takes word lane i+N-a when i < a, else keeps old.
    always_comb begin
      r_pick = old[8*i +: 8];
      for (int k = 0; k < NLANE; k++) begin
        if (addr != '0 && k == i + NLANE - int'(addr)) r_pick = word[8*k +: 8];
      end
    end

    assign merged[8*i +: 8] = left ? l_pick : r_pick;
  end

endmodule

// File: rtl/ld_align_unit.sv
module ld_align_unit
  import ld_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NLANE = DATA_W / 8,
  localparam int AW    = $clog2(NLANE)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   in_op,
  input  logic [AW-1:0]     in_addr,
  input  logic [DATA_W-1:0] in_word,
  input  logic [DATA_W-1:0] in_old,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_misalign
);

  ld_dec_t           dec;
  logic [DATA_W-1:0] ext_val;
  logic [DATA_W-1:0] merge_val;
  logic [DATA_W-1:0] next_data;
  logic              next_mis;

  ld_decode u_dec (
    .op  (in_op),
    .dec (dec)
  );

  ld_extract #(.DATA_W(DATA_W)) u_ext (
    .word       (in_word),
    .addr       (in_addr),
    .is_half    (dec.kind == K_HALF),
    .signed_ext (dec.signed_ext),
    .ext        (ext_val)
  );

  ld_merge #(.DATA_W(DATA_W)) u_mrg (
    .word   (in_word),
    .old    (in_old),
    .addr   (in_addr),
    .left   (dec.kind == K_LEFT),
    .merged (merge_val)
  );

  always_comb begin
    case (dec.kind)
      K_BYTE, K_HALF:  next_data = ext_val;
      K_WORD:          next_data = in_word;
      K_LEFT, K_RIGHT: next_data = merge_val;
      default:         next_data = in_old;
    endcase
    next_mis = (dec.kind == K_WORD) && (in_addr != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_data     <= '0;
      out_misalign <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data     <= next_data;
        out_misalign <= next_mis;
      end
    end
  end

endmodule

// File: rtl/ld_align_chk.sv
module ld_align_chk
  import ld_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int AW = $clog2(DATA_W / 8)
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [OP_W-1:0]   in_op,
  input logic [AW-1:0]     in_addr,
  input logic [DATA_W-1:0] in_word,
  input logic [DATA_W-1:0] in_old,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_misalign
);

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R2
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_data) && $stable(out_misalign)));

  // R6
  word_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_op == OPC_WORD || in_op == OPC_LINKED))
      |=> out_data == $past(in_word));

  // R9
  right_zero_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OPC_RIGHT && in_addr == '0)
      |=> out_data == $past(in_old));

  // R10
  mis_only_word_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op != OPC_WORD && in_op != OPC_LINKED) |=> !out_misalign);

  // R10
  mis_word_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_op == OPC_WORD || in_op == OPC_LINKED))
      |=> out_misalign == ($past(in_addr) != '0));

endmodule

bind ld_align_unit ld_align_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .in_op        (in_op),
  .in_addr      (in_addr),
  .in_word      (in_word),
  .in_old       (in_old),
  .out_valid    (out_valid),
  .out_data     (out_data),
  .out_misalign (out_misalign)
);

// File: tb/ld_align_unit_test.sv
module ld_align_unit_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [5:0]  in_op;
  logic [1:0]  in_addr;
  logic [31:0] in_word;
  logic [31:0] in_old;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_misalign;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  ld_align_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_addr(in_addr), .in_word(in_word), .in_old(in_old),
    .out_valid(out_valid), .out_data(out_data), .out_misalign(out_misalign)
  );

  localparam logic [31:0] W = 32'h8F7E_C35A;
  localparam logic [31:0] O = 32'h1122_3344;

  typedef struct packed {
    logic [5:0]  op;
    logic [1:0]  addr;
    logic [31:0] res;
    logic        mis;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VT [NV] = '{
    '{6'd32, 2'd0, 32'h0000_005A, 1'b0, 8'd3},   // R3
    '{6'd32, 2'd1, 32'hFFFF_FFC3, 1'b0, 8'd3},   // R3
    '{6'd32, 2'd2, 32'h0000_007E, 1'b0, 8'd3},   // R3
    '{6'd32, 2'd3, 32'hFFFF_FF8F, 1'b0, 8'd3},   // R3
    '{6'd36, 2'd1, 32'h0000_00C3, 1'b0, 8'd4},   // R4
    '{6'd36, 2'd3, 32'h0000_008F, 1'b0, 8'd4},   // R4
    '{6'd36, 2'd0, 32'h0000_005A, 1'b0, 8'd4},   // R4
    '{6'd33, 2'd0, 32'hFFFF_C35A, 1'b0, 8'd5},   // R5
    '{6'd33, 2'd1, 32'hFFFF_C35A, 1'b0, 8'd5},   // R5 bit 0 ignored
    '{6'd33, 2'd2, 32'hFFFF_8F7E, 1'b0, 8'd5},   // R5
    '{6'd33, 2'd3, 32'hFFFF_8F7E, 1'b0, 8'd5},   // R5
    '{6'd37, 2'd0, 32'h0000_C35A, 1'b0, 8'd5},   // R5
    '{6'd37, 2'd2, 32'h0000_8F7E, 1'b0, 8'd5},   // R5
    '{6'd35, 2'd0, W,             1'b0, 8'd6},   // R6
    '{6'd35, 2'd2, W,             1'b1, 8'd6},   // R6 with R10 flag
    '{6'd48, 2'd0, W,             1'b0, 8'd6},   // R6
    '{6'd48, 2'd3, W,             1'b1, 8'd6},   // R6 with R10 flag
    '{6'd35, 2'd1, W,             1'b1, 8'd10},  // R10
    '{6'd34, 2'd0, W,             1'b0, 8'd7},   // R7
    '{6'd34, 2'd1, 32'h7EC3_5A44, 1'b0, 8'd7},   // R7
    '{6'd34, 2'd2, 32'hC35A_3344, 1'b0, 8'd7},   // R7
    '{6'd34, 2'd3, 32'h5A22_3344, 1'b0, 8'd7},   // R7
    '{6'd38, 2'd1, 32'h1122_338F, 1'b0, 8'd8},   // R8
    '{6'd38, 2'd2, 32'h1122_8F7E, 1'b0, 8'd8},   // R8
    '{6'd38, 2'd3, 32'h118F_7EC3, 1'b0, 8'd8},   // R8
    '{6'd38, 2'd0, O,             1'b0, 8'd9},   // R9
    '{6'd32, 2'd3, 32'hFFFF_FF8F, 1'b0, 8'd10},  // R10 no flag on byte
    '{6'd34, 2'd2, 32'hC35A_3344, 1'b0, 8'd10},  // R10 no flag on merge
    '{6'd0,  2'd1, O,             1'b0, 8'd11},  // R11
    '{6'd39, 2'd2, O,             1'b0, 8'd11},  // R11
    '{6'd63, 2'd0, O,             1'b0, 8'd11},  // R11
    '{6'd49, 2'd3, O,             1'b0, 8'd11}   // R11
  };

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic present(input logic [5:0] op, input logic [1:0] a,
                         input logic [31:0] w, input logic [31:0] o);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_addr = a; in_word = w; in_old = o;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_op = '0; in_addr = '0;
    in_word = '0; in_old = '0;
    repeat (3) @(negedge clk);
    // R1: outputs cleared under reset
    check("R1 valid", {31'd0, out_valid}, 32'd0);
    check("R1 data", out_data, 32'd0);
    check("R1 mis", {31'd0, out_misalign}, 32'd0);
    rst = 1'b0;

    // Vector table: result sampled one edge after presentation
    for (int i = 0; i < NV; i++) begin
      present(VT[i].op, VT[i].addr, W, O);
      check($sformatf("R%0d vec%0d valid", VT[i].req, i), {31'd0, out_valid}, 32'd1);
      check($sformatf("R%0d vec%0d data", VT[i].req, i), out_data, VT[i].res);
      check($sformatf("R%0d vec%0d mis", VT[i].req, i), {31'd0, out_misalign},
            {31'd0, VT[i].mis});
    end

    // R2: hold while idle; changed inputs with in_valid low are ignored
    present(6'd35, 2'd1, 32'hDEAD_BEEF, O);
    @(negedge clk);
    in_op = 6'd32; in_addr = 2'd0; in_word = 32'h0000_0001;
    @(negedge clk);
    check("R2 idle valid", {31'd0, out_valid}, 32'd0);
    check("R2 hold data", out_data, 32'hDEAD_BEEF);
    check("R2 hold mis", {31'd0, out_misalign}, 32'd1);

    // R2: back-to-back loads, each result one cycle after its load
    @(negedge clk);
    in_valid = 1'b1; in_op = 6'd36; in_addr = 2'd2; in_word = W; in_old = O;
    @(negedge clk);
    check("R2 b2b first", out_data, 32'h0000_007E);
    in_op = 6'd34; in_addr = 2'd1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 b2b second", out_data, 32'h7EC3_5A44);
    check("R2 b2b valid", {31'd0, out_valid}, 32'd1);

    // R1: reset in mid-run clears state
    present(6'd35, 2'd3, W, O);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid data", out_data, 32'd0);
    check("R1 mid mis", {31'd0, out_misalign}, 32'd0);
    rst = 1'b0;

    // R9 with a different old value
    present(6'd38, 2'd0, 32'hFFFF_FFFF, 32'h0BAD_F00D);
    check("R9 keep old", out_data, 32'h0BAD_F00D);

    finish_run();
  end

endmodule